// File: doc/BRIEF.md
# Hibernate and Wakeup Sequencer

This block is a small power-control state machine clocked by the slow 32 kHz reference. Software puts the system to sleep by writing the hibernate command word. The block then drops its power-enable output and watches an active-low wakeup pin. A wakeup counts only once the pin has stayed asserted for a programmed minimum number of reference ticks, so short glitches and bounces do not wake the system.

Once a wakeup is accepted, power-enable returns and the reset output is held low for a programmed number of ticks. After that the block is back in the running state. Both durations are held in register fields whose low bits are not implemented, so each duration is a multiple of 32 ticks. Writes go through a simple write-ready gate: after each accepted write, the gate is closed for one cycle.

Register words by address: 0 is the hibernate command and status word, 1 is the wakeup filter, and 2 is the reset count. All other addresses read as zero.

Top module: `hib_wake_seq`

## Requirements
- R1: After reset, pwr_en = 1, rst_out_n = 1 and wr_rdy = 1, and register words 0, 1 and 2 read as 0.
- R2: In the running state, an accepted write to address 0 with data bit 0 = 1 drives pwr_en low from the next cycle. A write to address 0 with bit 0 = 0 has no effect.
- R3: The wakeup filter word (address 1) keeps only data bits 15:5. All other bits read 0, so a write of all ones reads back 0x0000FFE0.
- R4: The reset count word (address 2) keeps only data bits 11:5. All other bits read 0, so a write of all ones reads back 0x00000FE0.
- R5: wake_n is active low and passes through two synchronizing flops. With filter value F > 0, a wakeup is accepted on the (F+1)-th consecutive asserted synchronized sample. If wake_n falls just before clock edge 1, pwr_en is first high after edge F+3.
- R6: If the synchronized pin deasserts before acceptance, the block returns to hibernate with pwr_en low and its count cleared. A later attempt needs the full duration again. Holding the pin for exactly F cycles is rejected, and holding it for F+1 cycles is accepted.
- R7: A filter value of 0 accepts the wakeup on the first asserted synchronized sample, so pwr_en is high after edge 3.
- R8: After acceptance with reset count R > 0, rst_out_n is low for exactly R cycles while pwr_en is high. It then returns high and the block is running.
- R9: A reset count of 0 skips the reset pulse: rst_out_n stays high throughout the wakeup.
- R10: An accepted write (wr_en with wr_rdy high) drops wr_rdy for the following cycle. A write presented while wr_rdy is low is ignored.
- R11: Address 0 reads 1 in every state other than running, and 0 while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write word address |
| wr_data | input | 32 | Register write data |
| wr_rdy | output | 1 | High when a write will be accepted |
| rd_addr | input | 2 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| wake_n | input | 1 | Wakeup pin, active low, asynchronous |
| pwr_en | output | 1 | System power enable |
| rst_out_n | output | 1 | System reset output, active low |

## Verification
The filter decision and the pin release can fall on the same clock edge. At that edge the count reaches the threshold, and the synchronized pin may deassert in the same cycle. The bench provokes this by holding wake_n low for exactly F cycles and then for F+1 cycles. It expects a rejection in the first case and an acceptance in the second, because release takes priority over acceptance. It judges each case by whether pwr_en stays low or rises within a few cycles.

// File: rtl/hib_wake_seq.sv
module hib_wake_seq #(
  parameter int DW      = 32,
  parameter int FILT_LO = 5,
  parameter int FILT_HI = 15,
  parameter int RCNT_LO = 5,
  parameter int RCNT_HI = 11,
  parameter int CW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          wr_rdy,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wake_n,
  output logic          pwr_en,
  output logic          rst_out_n
);
  localparam int FW = FILT_HI - FILT_LO + 1;
  localparam int RW = RCNT_HI - RCNT_LO + 1;

  typedef enum logic [1:0] {S_RUN, S_HIB, S_FILT, S_RST} st_t;

  st_t           st;
  logic [FW-1:0] filt_q;
  logic [RW-1:0] rcnt_q;
  logic [CW-1:0] cnt;
  logic          busy, s1, s2;

  wire           wr_ok  = wr_en & ~busy;
  wire           hib_go = wr_ok && wr_addr == 2'd0 && wr_data[0];
  wire           act    = ~s2;
  wire [CW-1:0]  filt_t = CW'({filt_q, {FILT_LO{1'b0}}});
  wire [CW-1:0]  rcnt_t = CW'({rcnt_q, {RCNT_LO{1'b0}}});
  wire           r_zero = (rcnt_q == '0);

  assign wr_rdy    = ~busy;
  assign pwr_en    = (st == S_RUN) || (st == S_RST);
  assign rst_out_n = (st != S_RST);

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = DW'(st != S_RUN);
      2'd1:    rd_data = DW'(filt_t);
      2'd2:    rd_data = DW'(rcnt_t);
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_RUN;
      cnt    <= '0;
      filt_q <= '0;
      rcnt_q <= '0;
      busy   <= 1'b0;
      s1     <= 1'b1;
      s2     <= 1'b1;
    end else begin
      s1   <= wake_n;
      s2   <= s1;
      busy <= wr_ok;
      if (wr_ok && wr_addr == 2'd1) filt_q <= wr_data[FILT_HI:FILT_LO];
      if (wr_ok && wr_addr == 2'd2) rcnt_q <= wr_data[RCNT_HI:RCNT_LO];
      case (st)
        S_RUN: begin
          cnt <= '0;
          if (hib_go) st <= S_HIB;
        end
        S_HIB: begin
          if (act) begin
            if (filt_t == '0) begin
              cnt <= '0;
              st  <= r_zero ? S_RUN : S_RST;
            end else begin
              cnt <= CW'(1);
              st  <= S_FILT;
            end
          end
        end
        S_FILT: begin
          if (!act) begin
            cnt <= '0;
            st  <= S_HIB;
          end else if (cnt >= filt_t) begin
            cnt <= '0;
            st  <= r_zero ? S_RUN : S_RST;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt + 1'b1 >= rcnt_t) begin
            cnt <= '0;
            st  <= S_RUN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  a_r2_power_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> $past(hib_go));
  a_r6_stay_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en && s2) |=> !pwr_en);
  a_r5_wake_needs_pin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> $past(act));
  a_r8_pulse_from_off: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) |-> $past(!pwr_en));
  a_r10_gate_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_rdy) |=> !wr_rdy);
endmodule

// File: tb/hib_wake_seq_test.sv
module hib_wake_seq_test;
  logic        clk = 0, rst_n = 0, wr_en = 0, wake_n = 1;
  logic [1:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0;
  logic        wr_rdy, pwr_en, rst_out_n;
  logic [31:0] rd_data;
  int          n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  hib_wake_seq uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_rdy(wr_rdy), .rd_addr(rd_addr), .rd_data(rd_data),
    .wake_n(wake_n), .pwr_en(pwr_en), .rst_out_n(rst_out_n));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    while (!wr_rdy) @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 pwr_en", pwr_en, 1);
    chk("R1 rst_out_n", rst_out_n, 1);
    chk("R1 wr_rdy", wr_rdy, 1);
    for (int a = 0; a < 3; a++) begin
      rd(a[1:0], d);
      chk("R1 reg", d, 0);
    end
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(1, 32'hFFFF_FFFF); rd(1, d); chk("R3 filter mask", d, 32'h0000_FFE0);
    wr(2, 32'hFFFF_FFFF); rd(2, d); chk("R4 count mask", d, 32'h0000_0FE0);
    @(negedge clk);
    wr_en = 1; wr_addr = 1; wr_data = 32'h20;
    @(negedge clk);
    chk("R10 gate low", wr_rdy, 0);
    wr_data = 32'h40;
    @(negedge clk);
    wr_en = 0;
    rd(1, d); chk("R10 blocked write ignored", d, 32'h20);
  endtask

  task automatic t_hib_zero();
    logic [31:0] d;
    wr(0, 0);
    chk("R2 bit0 clear no effect", pwr_en, 1);
    rd(0, d); chk("R11 run reads 0", d, 0);
  endtask

  task automatic enter_hib();
    logic [31:0] d;
    wr(0, 1);
    chk("R2 power off", pwr_en, 0);
    rd(0, d); chk("R11 hib reads 1", d, 1);
  endtask

  task automatic wake(int f, int r, string req);
    int first = 0, lows = 0;
    @(negedge clk);
    wake_n = 0;
    for (int n = 1; n <= f + r + 6; n++) begin
      @(negedge clk);
      if (pwr_en && first == 0) first = n;
      if (!rst_out_n) begin
        lows++;
        if (!pwr_en) chk({req, " power during reset"}, pwr_en, 1);
      end
    end
    chk({req, " power-up cycle"}, first, f + 3);
    chk({req, " reset length"}, lows, r);
    chk({req, " final rst_out_n"}, rst_out_n, 1);
    chk({req, " final pwr_en"}, pwr_en, 1);
    wake_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_glitch();
    logic [31:0] d;
    wr(1, 32'h20); wr(2, 32'h20);
    enter_hib();
    wake_n = 0;
    repeat (32) @(negedge clk);
    wake_n = 1;
    for (int n = 0; n < 8; n++) @(negedge clk);
    chk("R6 F-cycle press rejected", pwr_en, 0);
    rd(0, d); chk("R11 still not running", d, 1);
    wake(32, 32, "R6 full retry");
    enter_hib();
    wake_n = 0;
    repeat (33) @(negedge clk);
    wake_n = 1;
    repeat (3) @(negedge clk);
    chk("R6 F+1 press accepted", pwr_en, 1);
    repeat (40) @(negedge clk);
    chk("R6 back running", rst_out_n, 1);
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_hib_zero();
    wr(2, 32'h3F);
    enter_hib();
    wake(32, 32, "R5 R8 filter 32");
    wr(1, 32'h1F); wr(2, 32'h20);
    enter_hib();
    wake(0, 32, "R7 zero filter");
    wr(1, 32'h40); wr(2, 32'h1F);
    enter_hib();
    wake(64, 0, "R9 zero count");
    t_glitch();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule